// File: doc/BRIEF.md
# Programmable Line Density Scaler

This block rescales a scanned image one pixel per clock, along the pixel direction and along the line direction. Each direction has its own step register and its own fractional phase accumulator. When an accumulator overflows, an output is produced. If it does not overflow, the input is dropped. If it overflows twice, the output is marked for doubling. Dark content is never discarded. A dropped pixel is folded into the next pixel that is kept, and a dropped line is folded, pixel by pixel, into the next line that is kept. A separate pairing mode halves the line count by taking the darker value of each pair of lines, one pixel at a time.

Pixel codes run from white (0) to darkest (all ones). For a one-bit stream, 1 means black. Doubling is not replayed inside the block. Instead, each output beat carries a flag that says whether it stands for two identical pixels, and the first beat of each line carries a flag that says whether that line stands for two identical lines. The downstream writer performs the replication. A line may hold at most `MAX_PIX` input pixels. Configuration changes only between pages.

Top module: `line_density_scaler`

## Requirements
- R1: After reset, and until the first input pixel has been processed, `out_vld` is 0.
- R2: The pixel-direction step N (1..256) scales by N/128. Counting input pixels p = 1, 2, … from each line start, pixel p yields c = floor(p·N/128) − floor((p−1)·N/128) copies. c = 0 gives no beat, c = 1 gives one beat with `out_dbl` = 0, and c = 2 gives one beat with `out_dbl` = 1.
- R3: The value of each beat is the largest pixel code among the input pixels consumed since the previous beat of the same line, including the pixel that produced the beat.
- R4: The line-direction step M (1..512) scales by M/256. Counting lines q = 1, 2, … from each page start, line q yields floor(q·M/256) − floor((q−1)·M/256) copies. With 0 copies the line is not output. With 2 copies, `out_ldbl` = 1 on every beat of that line.
- R5: Each output beat at beat position j of a line is the largest of its own value and the values at beat position j of every line dropped since the previous output line of the same page.
- R6: When `cfg_or_pair` = 1, M is ignored. Odd-numbered lines of a page are not output. Each even-numbered line is output once (`out_ldbl` = 0), with each beat being the larger of the two lines' beats at that position.
- R7: The pixel accumulator restarts at every line start, and the line accumulator restarts at every page start. A page start also discards any dropped-line content still pending from the previous page.
- R8: Each beat appears on the outputs exactly one clock after the input pixel that produces it. `out_sol` marks the first beat of a line and `out_eol` marks the beat produced by the line's last pixel.
- R9: The last pixel of a line always yields at least one copy, carrying any pending dark pixels, even when the formula in R2 gives 0.
- R10: A line that yields no copies produces no `out_vld` at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hstep | input | 9 | Pixel-direction step N, scale N/128 |
| cfg_vstep | input | 10 | Line-direction step M, scale M/256 |
| cfg_or_pair | input | 1 | 1: merge line pairs, output one line per pair |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | First line of page (qualified by in_sol) |
| in_sol | input | 1 | First pixel of line |
| in_eol | input | 1 | Last pixel of line |
| in_pix | input | 4 | Pixel code, 0 white |
| out_vld | output | 1 | Output beat valid |
| out_pix | output | 4 | Output pixel code |
| out_dbl | output | 1 | Beat stands for two pixels |
| out_sol | output | 1 | First beat of output line |
| out_eol | output | 1 | Last beat of output line |
| out_ldbl | output | 1 | Current line stands for two lines |

## Verification
The bench runs pages through the block with several settings:
- Unity steps show that the block passes pixels through unchanged.
- Half and odd fractional pixel steps show whether the accumulator's overflow pattern is right and whether dark pixels survive decimation.
- Steps above unity in each direction exercise the doubling flags.
- Line steps below unity, together with pairing mode, show whether dropped lines are folded into the right beat positions.
- The smallest steps and one-pixel lines exercise the end-of-line flush and the fully dropped page.

A two-page sequence checks that dark content from a dropped line does not leak into the next page.

// File: rtl/ldsc_pkg.sv
package ldsc_pkg;

  typedef enum logic [1:0] {
    CNT_ZERO = 2'd0,
    CNT_ONE  = 2'd1,
    CNT_TWO  = 2'd2,
    CNT_BAD  = 2'd3
  } copy_cnt_e;

endpackage

// File: rtl/ldsc_hstep.sv
module ldsc_hstep #(
  parameter int PIX_W = 4,
  parameter int FRAC  = 7,
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_sol,
  input  logic               in_eol,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic [FRAC+1:0]    cfg_step,
  output logic               beat,
  output logic               beat_dbl,
  output logic [PIX_W-1:0]   beat_pix,
  output logic [IDX_W-1:0]   beat_idx
);
  import ldsc_pkg::*;

  localparam int SUM_W = FRAC + 2;
  localparam logic [SUM_W-1:0] UNITY = SUM_W'(1) << FRAC;

  logic [FRAC-1:0]  acc_q, acc_d, acc_base;
  logic [PIX_W-1:0] pend_q, pend_d, pend_base;
  logic [IDX_W-1:0] idx_q, idx_d, idx_base;
  logic [SUM_W-1:0] sum;
  copy_cnt_e        kc;
  logic [PIX_W-1:0] merged;

  // next-state logic
  always_comb begin
    acc_base  = in_sol ? '0 : acc_q;
    pend_base = in_sol ? '0 : pend_q;
    idx_base  = in_sol ? '0 : idx_q;
    sum       = {2'b00, acc_base} + cfg_step;
    kc        = copy_cnt_e'(sum[SUM_W-1:FRAC]);
    merged    = (pend_base > in_pix) ? pend_base : in_pix;
    beat      = in_vld && ((kc != CNT_ZERO) || in_eol);
    beat_dbl  = beat && (kc == CNT_TWO);
    beat_pix  = merged;
    beat_idx  = idx_base;
    acc_d     = sum[FRAC-1:0];
    pend_d    = beat ? '0 : merged;
    idx_d     = beat ? idx_base + IDX_W'(1) : idx_base;
  end

  // registers, enabled by input valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= '0;
      idx_q  <= '0;
    end else if (in_vld) begin
      acc_q  <= acc_d;
      pend_q <= pend_d;
      idx_q  <= idx_d;
    end
  end

  // R2: a doubled beat needs a step above unity
  p_dbl_enlarge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_dbl |-> (cfg_step > UNITY));

  // R2: at unity or above every pixel produces a beat
  p_unity_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (cfg_step >= UNITY)) |-> beat);

endmodule

// File: rtl/ldsc_vstep.sv
module ldsc_vstep #(
  parameter int FRAC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic            in_sol,
  input  logic            in_sof,
  input  logic [FRAC+1:0] cfg_step,
  input  logic            cfg_or,
  output logic            line_emit,
  output logic            line_dbl
);
  import ldsc_pkg::*;

  localparam int SUM_W = FRAC + 2;
  localparam logic [SUM_W-1:0] UNITY = SUM_W'(1) << FRAC;

  logic [FRAC-1:0]  acc_q, acc_base;
  logic             pair_q, pair_base;
  logic             emit_q, dbl_q;
  logic [SUM_W-1:0] sum;
  copy_cnt_e        kc;
  logic             new_emit, new_dbl, line_go;

  always_comb begin
    line_go   = in_vld && in_sol;
    acc_base  = in_sof ? '0 : acc_q;
    pair_base = in_sof ? 1'b0 : pair_q;
    sum       = {2'b00, acc_base} + cfg_step;
    kc        = copy_cnt_e'(sum[SUM_W-1:FRAC]);
    new_emit  = cfg_or ? pair_base : (kc != CNT_ZERO);
    new_dbl   = cfg_or ? 1'b0 : (kc == CNT_TWO);
    line_emit = line_go ? new_emit : emit_q;
    line_dbl  = line_go ? new_dbl  : dbl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pair_q <= 1'b0;
      emit_q <= 1'b0;
      dbl_q  <= 1'b0;
    end else if (line_go) begin
      acc_q  <= sum[FRAC-1:0];
      pair_q <= ~pair_base;
      emit_q <= new_emit;
      dbl_q  <= new_dbl;
    end
  end

  // R6: the first line of a page is never output in pairing mode
  p_or_first_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_or && in_vld && in_sol && in_sof) |-> !line_emit);

  // R4: a doubled line needs a line step above unity
  p_ldbl_enlarge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && line_dbl && !cfg_or) |-> (cfg_step > UNITY));

endmodule

// File: rtl/ldsc_linebuf.sv
module ldsc_linebuf #(
  parameter int PIX_W = 4,
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem_q [DEPTH];

  always_comb begin
    rdata = clr ? '0 : mem_q[idx];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             hit;
    logic [PIX_W-1:0] ent_d;
    always_comb begin
      hit   = we && (idx == IDX_W'(e));
      ent_d = hit ? wdata : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (hit || clr) begin
        mem_q[e] <= ent_d;
      end
    end
  end

endmodule

// File: rtl/line_density_scaler.sv
module line_density_scaler #(
  parameter int PIX_W   = 4,
  parameter int MAX_PIX = 64,
  parameter int H_FRAC  = 7,
  parameter int V_FRAC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_FRAC+1:0] cfg_hstep,
  input  logic [V_FRAC+1:0] cfg_vstep,
  input  logic              cfg_or_pair,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic              in_eol,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_vld,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_dbl,
  output logic              out_sol,
  output logic              out_eol,
  output logic              out_ldbl
);
  localparam int IDX_W = (MAX_PIX > 1) ? $clog2(MAX_PIX) : 1;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             beat, beat_dbl;
  logic [PIX_W-1:0] beat_pix;
  logic [IDX_W-1:0] beat_idx;
  logic             line_emit, line_dbl;
  logic             page_clr;
  logic [PIX_W-1:0] buf_rd, merged, buf_wr;
  logic             emit_beat;

  ldsc_hstep #(.PIX_W(PIX_W), .FRAC(H_FRAC), .IDX_W(IDX_W)) u_hstep (
    .clk(clk), .rst_n(rst_sync_n), .in_vld(in_vld), .in_sol(in_sol),
    .in_eol(in_eol), .in_pix(in_pix), .cfg_step(cfg_hstep),
    .beat(beat), .beat_dbl(beat_dbl), .beat_pix(beat_pix), .beat_idx(beat_idx)
  );

  ldsc_vstep #(.FRAC(V_FRAC)) u_vstep (
    .clk(clk), .rst_n(rst_sync_n), .in_vld(in_vld), .in_sol(in_sol),
    .in_sof(in_sof), .cfg_step(cfg_vstep), .cfg_or(cfg_or_pair),
    .line_emit(line_emit), .line_dbl(line_dbl)
  );

  ldsc_linebuf #(.PIX_W(PIX_W), .DEPTH(MAX_PIX), .IDX_W(IDX_W)) u_linebuf (
    .clk(clk), .rst_n(rst_sync_n), .clr(page_clr), .we(beat),
    .idx(beat_idx), .wdata(buf_wr), .rdata(buf_rd)
  );

  always_comb begin
    page_clr  = in_vld && in_sol && in_sof;
    merged    = (buf_rd > beat_pix) ? buf_rd : beat_pix;
    buf_wr    = line_emit ? '0 : merged;
    emit_beat = beat && line_emit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld  <= 1'b0;
      out_pix  <= '0;
      out_dbl  <= 1'b0;
      out_sol  <= 1'b0;
      out_eol  <= 1'b0;
      out_ldbl <= 1'b0;
    end else begin
      out_vld <= emit_beat;
      if (emit_beat) begin
        out_pix  <= merged;
        out_dbl  <= beat_dbl;
        out_sol  <= (beat_idx == '0);
        out_eol  <= in_eol;
        out_ldbl <= line_dbl;
      end
    end
  end

  // R8: a kept last pixel shows up one clock later as an end-of-line beat
  p_eol_out_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && in_eol && line_emit) |=> (out_vld && out_eol));

  // R6: pairing mode never marks a line as doubled
  p_ldbl_or_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_vld && cfg_or_pair) |-> !out_ldbl);

  // R10: a dropped line produces no beat in the following clock
  p_drop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && !line_emit) |=> !out_vld);

endmodule

// File: tb/line_density_scaler_tb_top.sv
`timescale 1ns/1ps
module line_density_scaler_tb_top;
  localparam int PW = 4;
  localparam int NV = 10;
  localparam int VN  [NV] = '{128,  64, 256, 128, 128,  45, 200, 128, 1, 100};
  localparam int VM  [NV] = '{256, 256, 256, 128, 512,  77, 300,  77, 1, 256};
  localparam int VOR [NV] = '{  0,   0,   0,   0,   0,   0,   0,   1, 0,   0};
  localparam int VW  [NV] = '{ 10,  12,   8,   9,   7,  20,  11,   9, 5,   1};
  localparam int VL  [NV] = '{  3,   2,   2,   5,   2,   6,   4,   4, 3,   3};

  logic clk = 1'b0;
  logic rst_n;
  logic [8:0] cfg_hstep;
  logic [9:0] cfg_vstep;
  logic cfg_or_pair, in_vld, in_sof, in_sol, in_eol;
  logic [PW-1:0] in_pix;
  logic out_vld, out_dbl, out_sol, out_eol, out_ldbl;
  logic [PW-1:0] out_pix;

  always #2 clk = ~clk;

  line_density_scaler dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_hstep(cfg_hstep), .cfg_vstep(cfg_vstep),
    .cfg_or_pair(cfg_or_pair), .in_vld(in_vld), .in_sof(in_sof),
    .in_sol(in_sol), .in_eol(in_eol), .in_pix(in_pix), .out_vld(out_vld),
    .out_pix(out_pix), .out_dbl(out_dbl), .out_sol(out_sol),
    .out_eol(out_eol), .out_ldbl(out_ldbl)
  );

  int tests = 0;
  int fails = 0;
  int cap_n = 0;
  int cap_pix [2048];
  int cap_flg [2048];
  int exp_n;
  int exp_pix [2048];
  int exp_flg [2048];

  always @(negedge clk) begin
    if (rst_n && out_vld && cap_n < 2048) begin
      cap_pix[cap_n] = int'(out_pix);
      cap_flg[cap_n] = {28'd0, out_ldbl, out_eol, out_sol, out_dbl};
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int pixval(int q, int p, int seed, int cv);
    if (cv >= 0) return cv;
    if ((p * 5 + q * 3 + seed) % 7 == 0) return 15;
    return (p + q + seed) % 4;
  endfunction

  task automatic build_expected(int n, int m, int orm, int w, int l, int seed, int cv);
    int vm [256];
    for (int j = 0; j < 256; j++) vm[j] = 0;
    exp_n = 0;
    for (int q = 1; q <= l; q++) begin
      int lc, hp, j;
      if (orm != 0) lc = (q % 2 == 0) ? 1 : 0;
      else lc = (q * m) / 256 - ((q - 1) * m) / 256;
      hp = 0;
      j = 0;
      for (int p = 1; p <= w; p++) begin
        int v, hc, val;
        v = pixval(q, p, seed, cv);
        if (v > hp) hp = v;
        hc = (p * n) / 128 - ((p - 1) * n) / 128;
        if (p == w && hc == 0) hc = 1;
        if (hc > 0) begin
          val = (vm[j] > hp) ? vm[j] : hp;
          if (lc > 0) begin
            exp_pix[exp_n] = val;
            exp_flg[exp_n] = ((lc == 2) ? 8 : 0) + ((p == w) ? 4 : 0) +
                             ((j == 0) ? 2 : 0) + ((hc == 2) ? 1 : 0);
            exp_n++;
            vm[j] = 0;
          end else begin
            vm[j] = val;
          end
          j++;
          hp = 0;
        end
      end
    end
  endtask

  task automatic run_page(int n, int m, int orm, int w, int l, int seed, int cv);
    @(negedge clk);
    cfg_hstep   = 9'(n);
    cfg_vstep   = 10'(m);
    cfg_or_pair = (orm != 0);
    cap_n = 0;
    build_expected(n, m, orm, w, l, seed, cv);
    for (int q = 1; q <= l; q++) begin
      for (int p = 1; p <= w; p++) begin
        @(negedge clk);
        in_vld = 1'b1;
        in_sol = (p == 1);
        in_eol = (p == w);
        in_sof = (q == 1 && p == 1);
        in_pix = PW'(pixval(q, p, seed, cv));
      end
    end
    @(negedge clk);
    in_vld = 1'b0; in_sol = 1'b0; in_eol = 1'b0; in_sof = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(cap_n == exp_n, req, "beat count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_pix[i] == exp_pix[i], req, "pixel", cap_pix[i], exp_pix[i]);
      check(cap_flg[i] == exp_flg[i], req, "flags", cap_flg[i], exp_flg[i]);
    end
  endtask

  function automatic string vreq(int k);
    case (k)
      0: return "R2";  1: return "R3";  2: return "R2";  3: return "R5";
      4: return "R4";  5: return "R7";  6: return "R4";  7: return "R6";
      8: return "R10"; default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_hstep = 9'd128; cfg_vstep = 10'd256; cfg_or_pair = 1'b0;
    in_vld = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_eol = 1'b0; in_pix = '0;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0, "R1", "out_vld after reset", int'(out_vld), 0);

    for (int k = 0; k < NV; k++) begin
      run_page(VN[k], VM[k], VOR[k], VW[k], VL[k], k + 1, -1);
      compare(vreq(k));
    end

    // R8: exact one-clock latency with start and end flags
    @(negedge clk);
    cfg_hstep = 9'd128; cfg_vstep = 10'd256; cfg_or_pair = 1'b0;
    @(negedge clk);
    in_vld = 1'b1; in_sol = 1'b1; in_eol = 1'b1; in_sof = 1'b1; in_pix = 4'd9;
    @(negedge clk);
    in_vld = 1'b0; in_sol = 1'b0; in_eol = 1'b0; in_sof = 1'b0;
    check(out_vld && out_sol && out_eol, "R8", "flags one clock later",
          {out_vld, out_sol, out_eol}, 7);
    check(out_pix == 4'd9, "R8", "pixel one clock later", int'(out_pix), 9);
    @(negedge clk);
    check(out_vld == 1'b0, "R8", "single beat only", int'(out_vld), 0);

    // R7: dark content of a dropped last line does not reach the next page
    run_page(128, 128, 0, 4, 1, 0, 15);
    compare("R7");
    run_page(128, 256, 0, 4, 1, 0, 0);
    compare("R7");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule